// File: doc/BRIEF.md
# Store Gathering Burst Buffer

This block sits on the path from a processor's store port to an external memory write port. A software-programmable 32-byte window, the gather window, is held in a control register. Any store that falls inside that window is not sent to memory: its bytes are appended to a 128-byte circular staging buffer. Stores outside the window are forwarded unchanged to a pass-through write port.

Stores of 1, 2 or 4 bytes are packed back to back with no padding, so a 4-byte store may land at any byte position and may wrap around the end of the buffer. As soon as 32 or more bytes are staged, the block offers a 256-bit burst on a valid/ready port, always addressed to the base of the gather window. It keeps offering bursts while 32 or more bytes remain. A store that does not fit in the free space is held off with a low ready until a burst drains. Bit 0 of the control register reads back whether any bytes are staged.

Top module: `gather_burst_buf`

## Requirements
- R1: A store whose address bits [31:5] equal the gather base is captured and never appears on the pass-through port (pt_valid stays 0 for it).
- R2: A store outside the gather window is forwarded in the same cycle: pt_valid, pt_addr, pt_size and pt_data copy the store, and st_ready equals pt_ready.
- R3: Captured bytes are packed contiguously in arrival order. Within a store, the most significant used byte comes first. The oldest byte of a burst sits in bu_data[255:248] and the newest in bu_data[7:0].
- R4: bu_valid is 1 exactly when 32 or more bytes are staged. Each accepted burst removes 32 bytes. While a burst waits for bu_ready, bu_data holds steady.
- R5: bu_addr equals the gather base with bits [4:0] zero.
- R6: A captured store whose byte count exceeds the free space sees st_ready = 0. It is accepted once an accepted burst has made room.
- R7: cfg_rdata[0] reads 1 whenever at least one byte is staged and 0 otherwise. Writes to it have no effect.
- R8: A write with cfg_we loads bits [31:5] of cfg_wdata as the gather base. cfg_rdata[31:5] returns the base and cfg_rdata[4:1] read 0.
- R9: A synchronous reset (rst high at a clock edge) empties the buffer, clears cfg_rdata[0] and bu_valid, and loads the gather base from the GATHER_RST parameter.
- R10: Packing continues across the end of the 128-byte buffer, so a store that straddles the wrap point is split across it without reordering.
- R11: st_size code 0 selects 1 byte, code 1 selects 2 bytes, and codes 2 and 3 select 4 bytes. The bytes used are the low bytes of st_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data; bits [31:5] are the gather base |
| cfg_rdata | output | 32 | Gather base in [31:5], zeros in [4:1], not-empty flag in [0] |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted on this edge when high with st_valid |
| st_addr | input | 32 | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 32 | Store data, right-justified |
| pt_valid | output | 1 | Forwarded store valid |
| pt_ready | input | 1 | Memory accepts the forwarded store |
| pt_addr | output | 32 | Forwarded store address |
| pt_size | output | 2 | Forwarded store size code |
| pt_data | output | 32 | Forwarded store data |
| bu_valid | output | 1 | Burst available |
| bu_ready | input | 1 | Memory accepts the burst |
| bu_addr | output | 32 | Burst address (gather base) |
| bu_data | output | 256 | Burst payload, oldest byte most significant |

## Verification
A wrong byte count would show at the ports either as bu_valid rising one store too early or too late, or as st_ready dropping with space still free. Both are visible on the store that crosses the 32-byte or 128-byte threshold. A wrong write pointer or lane order would not show until the burst holding those bytes is offered, up to four bursts later, because the payload is the only view of the buffer contents. The stimulus therefore mixes store sizes and crosses the wrap point before the buffer is drained. A wrong routing decision shows in the same cycle as the store, on pt_valid.

// File: rtl/gbb_pkg.sv
package gbb_pkg;
   localparam int LANES  = 4;
   localparam int LANE_W = 8 * LANES;
   localparam int NB_W   = $clog2(LANES + 1);

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WALT = 2'd3
   } st_size_e;

   function automatic logic [NB_W-1:0] size_to_bytes(input logic [1:0] code);
      case (st_size_e'(code))
         SZ_BYTE: return NB_W'(1);
         SZ_HALF: return NB_W'(2);
         default: return NB_W'(4);
      endcase
   endfunction
endpackage

// File: rtl/gbb_route.sv
module gbb_route
   import gbb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5
) (
   input  logic [ADDR_W-1:OFF_W] st_win,
   input  logic [1:0]            st_size,
   input  logic [LANE_W-1:0]     st_data,
   input  logic [ADDR_W-1:OFF_W] gather_base,
   output logic                  hit,
   output logic [NB_W-1:0]       nbytes,
   output logic [LANE_W-1:0]     ordered
);
   logic [LANE_W-1:0] aligned;

   assign hit     = (st_win == gather_base);
   assign nbytes  = size_to_bytes(st_size);
   // push the used bytes to the top so lane 0 gets the first (most significant) byte
   assign aligned = st_data << (8 * (LANES - int'(nbytes)));

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign ordered[8*k +: 8] = aligned[8*(LANES-1-k) +: 8];
   end
endmodule

// File: rtl/gbb_ring.sv
module gbb_ring
   import gbb_pkg::*;
#(
   parameter int DEPTH = 128,
   parameter int BURST = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               push,
   input  logic [NB_W-1:0]    push_n,
   input  logic [LANE_W-1:0]  push_bytes,
   input  logic               pop,
   output logic               space_ok,
   output logic               burst_ok,
   output logic               nonempty,
   output logic [8*BURST-1:0] burst_data
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;
   localparam int OFF_W = $clog2(BURST);
   localparam int BLK_W = PTR_W - OFF_W;

   if ((DEPTH & (DEPTH - 1)) != 0 || (BURST & (BURST - 1)) != 0 ||
       DEPTH < 2 * BURST || BURST < LANES) begin : g_bad_cfg
      $error("gbb_ring: DEPTH and BURST must be powers of two, DEPTH >= 2*BURST, BURST >= LANES");
   end

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [BLK_W-1:0] rd_blk;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] add_amt, sub_amt;

   assign add_amt  = push ? CNT_W'(push_n) : '0;
   assign sub_amt  = pop  ? CNT_W'(BURST)  : '0;
   assign space_ok = (CNT_W'(DEPTH) - count) >= CNT_W'(push_n);
   assign burst_ok = count >= CNT_W'(BURST);
   assign nonempty = count != '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_blk <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(push_n);
         if (pop)  rd_blk <= rd_blk + 1'b1;
         count <= count + add_amt - sub_amt;
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (push && k < int'(push_n))
            mem[PTR_W'(wr_ptr + PTR_W'(k))] <= push_bytes[8*k +: 8];
      end
   end

   // bursts always start on a BURST boundary, so the read side is a fixed slice
   for (genvar j = 0; j < BURST; j++) begin : g_out
      assign burst_data[8*(BURST-1-j) +: 8] = mem[{rd_blk, OFF_W'(j)}];
   end
endmodule

// File: rtl/gather_burst_buf.sv
module gather_burst_buf
   import gbb_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                DEPTH      = 128,
   parameter int                BURST      = 32,
   parameter logic [ADDR_W-1:0] GATHER_RST = 32'h0000_1000
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_wdata,
   output logic [ADDR_W-1:0]  cfg_rdata,
   input  logic               st_valid,
   output logic               st_ready,
   input  logic [ADDR_W-1:0]  st_addr,
   input  logic [1:0]         st_size,
   input  logic [LANE_W-1:0]  st_data,
   output logic               pt_valid,
   input  logic               pt_ready,
   output logic [ADDR_W-1:0]  pt_addr,
   output logic [1:0]         pt_size,
   output logic [LANE_W-1:0]  pt_data,
   output logic               bu_valid,
   input  logic               bu_ready,
   output logic [ADDR_W-1:0]  bu_addr,
   output logic [8*BURST-1:0] bu_data
);
   localparam int OFF_W = $clog2(BURST);

   if (ADDR_W <= OFF_W + 1) begin : g_bad_addr
      $error("gather_burst_buf: ADDR_W too small for BURST");
   end

   logic [ADDR_W-1:OFF_W] gather_q;
   logic                  hit, space_ok, burst_ok, nonempty, push, pop;
   logic [NB_W-1:0]       nbytes;
   logic [LANE_W-1:0]     ordered;

   always_ff @(posedge clk) begin
      if (rst)         gather_q <= GATHER_RST[ADDR_W-1:OFF_W];
      else if (cfg_we) gather_q <= cfg_wdata[ADDR_W-1:OFF_W];
   end

   gbb_route #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_route (
      .st_win      (st_addr[ADDR_W-1:OFF_W]),
      .st_size     (st_size),
      .st_data     (st_data),
      .gather_base (gather_q),
      .hit         (hit),
      .nbytes      (nbytes),
      .ordered     (ordered)
   );

   gbb_ring #(.DEPTH(DEPTH), .BURST(BURST)) u_ring (
      .clk        (clk),
      .rst        (rst),
      .push       (push),
      .push_n     (nbytes),
      .push_bytes (ordered),
      .pop        (pop),
      .space_ok   (space_ok),
      .burst_ok   (burst_ok),
      .nonempty   (nonempty),
      .burst_data (bu_data)
   );

   assign push      = st_valid & hit & space_ok;
   assign pop       = burst_ok & bu_ready;
   assign st_ready  = hit ? space_ok : pt_ready;

   assign pt_valid  = st_valid & ~hit;
   assign pt_addr   = st_addr;
   assign pt_size   = st_size;
   assign pt_data   = st_data;

   assign bu_valid  = burst_ok;
   assign bu_addr   = {gather_q, {OFF_W{1'b0}}};
   assign cfg_rdata = {gather_q, {(OFF_W-1){1'b0}}, nonempty};
endmodule

// File: rtl/gbb_check.sv
module gbb_check #(
   parameter int ADDR_W = 32,
   parameter int BURST  = 32,
   parameter int DW     = 32
) (
   input logic               clk,
   input logic               rst,
   input logic [ADDR_W-1:0]  cfg_rdata,
   input logic               st_valid,
   input logic               st_ready,
   input logic [ADDR_W-1:0]  st_addr,
   input logic [DW-1:0]      st_data,
   input logic               pt_valid,
   input logic [ADDR_W-1:0]  pt_addr,
   input logic [DW-1:0]      pt_data,
   input logic               bu_valid,
   input logic               bu_ready,
   input logic [ADDR_W-1:0]  bu_addr,
   input logic [8*BURST-1:0] bu_data
);
   localparam int OFF_W = $clog2(BURST);

   logic in_win;
   assign in_win = st_addr[ADDR_W-1:OFF_W] == cfg_rdata[ADDR_W-1:OFF_W];

   p_no_leak_r1: assert property (@(posedge clk) disable iff (rst)
      pt_valid |-> !in_win);

   p_pt_route_r2: assert property (@(posedge clk) disable iff (rst)
      st_valid && !in_win |-> pt_valid && pt_addr == st_addr && pt_data == st_data);

   p_burst_hold_r4: assert property (@(posedge clk) disable iff (rst)
      bu_valid && !bu_ready |=> bu_valid && $stable(bu_data));

   p_burst_addr_r5: assert property (@(posedge clk) disable iff (rst)
      bu_valid |-> bu_addr == {cfg_rdata[ADDR_W-1:OFF_W], {OFF_W{1'b0}}});

   p_stall_full_r6: assert property (@(posedge clk) disable iff (rst)
      st_valid && in_win && !st_ready |-> bu_valid);

   p_capture_flag_r7: assert property (@(posedge clk) disable iff (rst)
      st_valid && st_ready && in_win |=> cfg_rdata[0]);

   p_burst_flag_r7: assert property (@(posedge clk) disable iff (rst)
      bu_valid |-> cfg_rdata[0]);

   p_cfg_zero_r8: assert property (@(posedge clk) disable iff (rst)
      cfg_rdata[OFF_W-1:1] == '0);
endmodule

bind gather_burst_buf gbb_check #(.ADDR_W(ADDR_W), .BURST(BURST), .DW(gbb_pkg::LANE_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cfg_rdata (cfg_rdata),
   .st_valid  (st_valid),
   .st_ready  (st_ready),
   .st_addr   (st_addr),
   .st_data   (st_data),
   .pt_valid  (pt_valid),
   .pt_addr   (pt_addr),
   .pt_data   (pt_data),
   .bu_valid  (bu_valid),
   .bu_ready  (bu_ready),
   .bu_addr   (bu_addr),
   .bu_data   (bu_data)
);

// File: tb/gather_burst_buf_test.sv
`timescale 1ns/1ps
module gather_burst_buf_test;
   localparam logic [31:0] RST_G = 32'h0000_1000;
   localparam logic [31:0] GBASE = 32'h0000_4A40;
   localparam logic [31:0] MISSB = 32'h0000_9000;
   // {hit, size code, offset, data}
   localparam logic [39:0] VECS [12] = '{
      {1'b1, 2'd2, 5'd0,  32'h1122_3344},
      {1'b1, 2'd1, 5'd1,  32'h0000_5566},
      {1'b0, 2'd2, 5'd4,  32'hDEAD_BEEF},
      {1'b1, 2'd0, 5'd2,  32'hABCD_EF77},
      {1'b1, 2'd2, 5'd3,  32'h8899_AABB},
      {1'b1, 2'd3, 5'd5,  32'hCCDD_EEFF},
      {1'b1, 2'd2, 5'd8,  32'h0102_0304},
      {1'b1, 2'd0, 5'd31, 32'h0000_0005},
      {1'b1, 2'd1, 5'd9,  32'h0000_0607},
      {1'b1, 2'd2, 5'd12, 32'h0809_0A0B},
      {1'b1, 2'd2, 5'd20, 32'h0C0D_0E0F},
      {1'b1, 2'd1, 5'd6,  32'hFFFF_1011}
   };

   logic         clk = 1'b0, rst = 1'b1;
   logic         cfg_we = 1'b0;
   logic [31:0]  cfg_wdata = '0, cfg_rdata;
   logic         st_valid = 1'b0, st_ready;
   logic [31:0]  st_addr = '0, st_data = '0;
   logic [1:0]   st_size = '0;
   logic         pt_valid, pt_ready = 1'b1;
   logic [31:0]  pt_addr, pt_data;
   logic [1:0]   pt_size;
   logic         bu_valid, bu_ready = 1'b0;
   logic [31:0]  bu_addr;
   logic [255:0] bu_data;

   int          nvec = 0, nbad = 0;
   logic [7:0]  mq [0:1023];
   int          mq_wr = 0, mq_rd = 0;
   logic [31:0] gq = RST_G;

   always #4 clk = ~clk;

   gather_burst_buf uut (.*);

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_level(input string tag);
      chk({tag, " flag R7"}, cfg_rdata[0], mq_wr != mq_rd);
      chk({tag, " bvalid R4"}, bu_valid, (mq_wr - mq_rd) >= 32);
   endtask

   task automatic do_store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
      int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      bit hit = (a[31:5] == gq[31:5]);
      @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_size = sz; st_data = d;
      #1;
      chk("R1 pt_valid follows window", pt_valid, !hit);
      if (!hit) begin
         chk("R2 pt_addr", pt_addr, a);
         chk("R2 pt_data", pt_data, d);
         chk("R2 pt_size", pt_size, sz);
         pt_ready = 1'b0; #1;
         chk("R2 ready low", st_ready, 1'b0);
         pt_ready = 1'b1; #1;
      end
      while (!st_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      st_valid = 1'b0;
      if (hit) for (int k = 0; k < n; k++) begin
         mq[mq_wr] = d[8*(n-1-k) +: 8];
         mq_wr++;
      end
   endtask

   task automatic pop_burst(input string tag);
      logic [255:0] e;
      for (int j = 0; j < 32; j++) e[8*(31-j) +: 8] = mq[mq_rd + j];
      @(negedge clk);
      chk({tag, " R4 valid"}, bu_valid, 1'b1);
      chk({tag, " R3 R10 data"}, bu_data, e);
      chk({tag, " R5 addr"}, bu_addr, {gq[31:5], 5'b0});
      bu_ready = 1'b1;
      @(negedge clk);
      bu_ready = 1'b0;
      mq_rd += 32;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R9 reset base", cfg_rdata, RST_G);
      chk("R9 reset bvalid", bu_valid, 1'b0);

      // R8: program base, low bits written as ones must read back zero; R7 bit 0 not writable
      cfg_we = 1'b1; cfg_wdata = GBASE | 32'h1F;
      @(negedge clk);
      cfg_we = 1'b0; gq = GBASE;
      chk("R8 R7 cfg readback", cfg_rdata, GBASE);

      // table walk: mixed sizes (R11), routing (R1 R2), packing
      foreach (VECS[i]) begin
         logic [31:0] a;
         a = (VECS[i][39] ? GBASE : MISSB) + 32'(VECS[i][36:32]);
         do_store(a, VECS[i][38:37], VECS[i][31:0]);
         chk_level($sformatf("vec%0d R11", i));
      end
      pop_burst("first burst R11");
      chk_level("after first burst");

      // fill: 1 byte then 31 words, crossing the buffer end (R10)
      do_store(GBASE + 32'd7, 2'd0, 32'h0000_00A5);
      for (int i = 0; i < 31; i++)
         do_store(GBASE + 32'd4, (i % 2 == 1) ? 2'd3 : 2'd2,
                  32'h1000_0000 * 32'(i % 16) + 32'h0001_0203 * 32'(i + 1));
      chk_level("filled 125");

      // R6: a 4-byte store does not fit in 3 free bytes
      @(negedge clk);
      st_valid = 1'b1; st_addr = GBASE; st_size = 2'd2; st_data = 32'hF1F2_F3F4;
      #1;
      chk("R6 stalled", st_ready, 1'b0);
      pop_burst("release R6");
      #1;
      chk("R6 ready after burst", st_ready, 1'b1);
      @(negedge clk);
      st_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         mq[mq_wr] = 8'hF1 + 8'(k);
         mq_wr++;
      end
      chk_level("after stalled store");

      pop_burst("drain a R10");
      pop_burst("drain b R10");
      pop_burst("drain c R10");
      chk_level("one byte left");

      // R9: reset mid-run empties buffer and restores base
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      mq_rd = mq_wr; gq = RST_G;
      #1;
      chk("R9 flag cleared", cfg_rdata[0], 1'b0);
      chk("R9 base restored", cfg_rdata, RST_G);
      chk("R9 bvalid", bu_valid, 1'b0);
      do_store(GBASE, 2'd2, 32'h5A5A_5A5A);
      chk_level("old window now forwarded R9");

      finish_run();
   end
endmodule